// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the write sequencer of a small parallel nonvolatile byte memory and its page buffer. It watches every accepted write (address and data) and decides, write by write, whether that byte may be loaded into the page buffer. Fixed address/data command sequences switch a protection mode on and off. While protection is on, each page or byte write must be preceded by a three-write unlock prefix. Writes that form part of a command are consumed as commands and never reach the page buffer.

The protection flag models nonvolatile storage. The synchronous reset stands for a power cycle and leaves that flag unchanged. The flag starts cleared, which is the shipped state. Two hardware inhibits also apply. A power-on delay counter blocks writes for a set number of cycles after each reset, and a low-supply input blocks writes while it is high. Inhibited writes are dropped completely. The page-load window is measured elsewhere: this block receives a one-cycle pulse when that window has expired.

Top module: `swp_sequencer`

## Requirements
- R1: After reset `prot_on` is 0 and `wr_allow` is 0. With protection off, a write that is not a command step raises `wr_allow` for one cycle, on the clock edge that samples `wr_valid`. `wr_allow` is never high in a cycle that does not follow a write.
- R2: The writes data AA at address 1555h, then 55 at 0AAAh, then A0 at 1555h set `prot_on` at the edge that samples the third write. No further writes are needed for this.
- R3: A write that matches the expected next command step is a command. Its `wr_allow` stays 0 in every mode.
- R4: While `prot_on` is 1 and no unlock prefix has been given in the current load window, every write has `wr_allow` 0.
- R5: With protection on, completing the R2 prefix unlocks data writes, so later non-command writes get `wr_allow` 1. A `load_win_done` pulse cancels the unlock, and writes after the pulse are blocked.
- R6: The six writes AA@1555h, 55@0AAAh, 80@1555h, AA@1555h, 55@0AAAh, 20@1555h clear `prot_on`. Writes after that are allowed.
- R7: A write that does not match the expected next step abandons the partial sequence. It is handled as a data write. If it equals the first step (AA@1555h), it counts as a new first step.
- R8: A `load_win_done` pulse abandons a partial command sequence, so the next write is matched against the first step.
- R9: `prot_on` keeps its value through `rst`. It starts at 0 before any command has been issued.
- R10: For POR_CYCLES cycles after reset, writes get `wr_allow` 0 and do not advance command recognition.
- R11: While `supply_low` is 1, writes get `wr_allow` 0 and do not advance command recognition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| wr_valid | input | 1 | One-cycle strobe for an accepted write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| load_win_done | input | 1 | Pulse when the page-load window has expired |
| supply_low | input | 1 | Low-supply inhibit |
| wr_allow | output | 1 | Registered: the sampled write may enter the page buffer |
| prot_on | output | 1 | Protection flag (persistent) |

## Verification
On every cycle, the assertions check the following. `wr_allow` follows only a write. It stays low after a command step, after an inhibited write and after a locked protected write. The power-on counter only counts down. `prot_on` changes only after a completed arm or disarm sequence. The unlock never exists without protection, and a window expiry returns recognition to idle. Only the bench scenarios can show that the exact byte sequences are recognised, and that a mismatching AA@1555h restarts recognition as a first step. They also show that inhibited writes leave recognition untouched and that protection survives a reset.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam logic [12:0] CMD_ADDR_HI = 13'h1555;
  localparam logic [12:0] CMD_ADDR_LO = 13'h0AAA;
  localparam logic [7:0]  KEY_FIRST   = 8'hAA;
  localparam logic [7:0]  KEY_SECOND  = 8'h55;
  localparam logic [7:0]  OP_ARM      = 8'hA0;
  localparam logic [7:0]  OP_ERASE    = 8'h80;
  localparam logic [7:0]  OP_DISARM   = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_E3, ST_E4, ST_E5
  } step_e;
endpackage

// File: rtl/swp_por_timer.sv
module swp_por_timer #(
  parameter int POR_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst,
  output logic busy
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= CW'(POR_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  a_r10_por_counts_down: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/swp_cmd_decoder.sv
module swp_cmd_decoder
  import swp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              win_done,
  output logic              is_cmd,
  output logic              arm_done,
  output logic              disarm_done
);
  step_e step_q, step_d;
  logic at_hi, at_lo, k1, k2;

  assign at_hi = (addr == ADDR_W'(CMD_ADDR_HI));
  assign at_lo = (addr == ADDR_W'(CMD_ADDR_LO));
  assign k1    = at_hi && (data == DATA_W'(KEY_FIRST));
  assign k2    = at_lo && (data == DATA_W'(KEY_SECOND));

  always_comb begin
    step_d      = step_q;
    is_cmd      = 1'b0;
    arm_done    = 1'b0;
    disarm_done = 1'b0;
    if (fire) begin
      // default: mismatch, restart and re-match as first step
      step_d = k1 ? ST_K1 : ST_IDLE;
      is_cmd = k1;
      unique case (step_q)
        ST_IDLE: ;
        ST_K1: if (k2) begin step_d = ST_K2; is_cmd = 1'b1; end
        ST_K2: begin
          if (at_hi && data == DATA_W'(OP_ARM)) begin
            step_d = ST_IDLE; is_cmd = 1'b1; arm_done = 1'b1;
          end else if (at_hi && data == DATA_W'(OP_ERASE)) begin
            step_d = ST_E3; is_cmd = 1'b1;
          end
        end
        ST_E3: if (k1) begin step_d = ST_E4; is_cmd = 1'b1; end
        ST_E4: if (k2) begin step_d = ST_E5; is_cmd = 1'b1; end
        ST_E5: if (at_hi && data == DATA_W'(OP_DISARM)) begin
          step_d = ST_IDLE; is_cmd = 1'b1; disarm_done = 1'b1;
        end
        default: step_d = ST_IDLE;
      endcase
    end else if (win_done) begin
      step_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_d;
  end

  a_r8_expiry_idles: assert property (@(posedge clk) disable iff (rst)
    (win_done && !fire) |=> (step_q == ST_IDLE));
  a_r7_mismatch_idles: assert property (@(posedge clk) disable iff (rst)
    (fire && !is_cmd) |=> (step_q == ST_IDLE));
endmodule

// File: rtl/swp_prot_state.sv
module swp_prot_state (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic disarm,
  input  logic win_done,
  output logic prot_q,
  output logic unlock_q
);
  // persistent flag: initial value is the shipped state, untouched by rst
  logic prot_r = 1'b0;

  always_ff @(posedge clk) begin
    if (arm)         prot_r <= 1'b1;
    else if (disarm) prot_r <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                      unlock_q <= 1'b0;
    else if (arm)                 unlock_q <= 1'b1;
    else if (disarm || win_done)  unlock_q <= 1'b0;
  end

  assign prot_q = prot_r;

  a_r2_rise_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_r) |-> $past(arm));
  a_r6_fall_needs_disarm: assert property (@(posedge clk) disable iff (rst)
    $fell(prot_r) |-> $past(disarm));
  a_r5_unlock_within_prot: assert property (@(posedge clk) disable iff (rst)
    unlock_q |-> prot_r);
  a_r5_unlock_drop_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(unlock_q) |-> $past(win_done || disarm || rst));
endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int POR_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_win_done,
  input  logic              supply_low,
  output logic              wr_allow,
  output logic              prot_on
);
  logic por_busy, fire, is_cmd, arm_done, disarm_done;
  logic prot_q, unlock_q, allow_d;

  swp_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .busy(por_busy));

  assign fire = wr_valid && !por_busy && !supply_low;

  swp_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .fire(fire), .addr(wr_addr), .data(wr_data),
    .win_done(load_win_done), .is_cmd(is_cmd), .arm_done(arm_done),
    .disarm_done(disarm_done));

  swp_prot_state u_prot (
    .clk(clk), .rst(rst), .arm(arm_done), .disarm(disarm_done),
    .win_done(load_win_done), .prot_q(prot_q), .unlock_q(unlock_q));

  assign allow_d = fire && !is_cmd && (!prot_q || unlock_q);

  always_ff @(posedge clk) begin
    if (rst) wr_allow <= 1'b0;
    else     wr_allow <= allow_d;
  end

  assign prot_on = prot_q;

  a_r1_allow_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_allow |-> $past(wr_valid));
  a_r3_cmd_not_stored: assert property (@(posedge clk) disable iff (rst)
    is_cmd |=> !wr_allow);
  a_r4_locked_blocks: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && prot_q && !unlock_q) |=> !wr_allow);
  a_r10_por_blocks: assert property (@(posedge clk) disable iff (rst)
    por_busy |=> !wr_allow);
  a_r11_low_blocks: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> !wr_allow);
endmodule

// File: tb/tb_swp_sequencer.sv
`timescale 1ns/1ps
module tb_swp_sequencer;
  logic clk = 1'b0, rst = 1'b1, wr_valid = 1'b0, load_win_done = 1'b0, supply_low = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_allow, prot_on;
  int checks = 0, failures = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  swp_sequencer #(.ADDR_W(13), .DATA_W(8), .POR_CYCLES(16)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_win_done(load_win_done), .supply_low(supply_low),
    .wr_allow(wr_allow), .prot_on(prot_on));

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: at each falling edge, the write driven last cycle has been sampled
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (wr_valid) begin
        item_t it;
        if (q.size() == 0) check(1'b1, 1'b0, "R1 unexpected write");
        else begin it = q.pop_front(); check(wr_allow, it.exp, it.tag); end
      end else if (wr_allow) check(wr_allow, 1'b0, "R1 allow without write");
    end
  end

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic exp, input string tag);
    item_t it;
    @(negedge clk); #1;
    it.exp = exp; it.tag = tag; q.push_back(it);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic expire();
    @(negedge clk); #1 load_win_done = 1'b1;
    @(negedge clk); #1 load_win_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wait_por();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(prot_on, 1'b0, "R1 R9 reset state prot_on");
    check(wr_allow, 1'b0, "R1 reset state wr_allow");
    // R10: writes inside the power-on delay are dropped and not recognised
    wr(13'h1555, 8'hAA, 1'b0, "R10 por write blocked");
    wait_por();
    wr(13'h0AAA, 8'h55, 1'b1, "R10 step after por write is data");
    wr(13'h1555, 8'hA0, 1'b1, "R10 no arm from por write");
    check(prot_on, 1'b0, "R10 prot stays off");
    wr(13'h0123, 8'h5A, 1'b1, "R1 plain write allowed");
    // R11: low supply
    supply_low = 1'b1;
    wr(13'h1555, 8'hAA, 1'b0, "R11 low supply blocks");
    supply_low = 1'b0;
    wr(13'h0AAA, 8'h55, 1'b1, "R11 no step recorded");
    wr(13'h1555, 8'hA0, 1'b1, "R11 no arm");
    check(prot_on, 1'b0, "R11 prot stays off");
    // R7: mismatch abandons sequence
    wr(13'h1555, 8'hAA, 1'b0, "R3 first step is command");
    wr(13'h0AAB, 8'h55, 1'b1, "R7 mismatch is data");
    wr(13'h1555, 8'hA0, 1'b1, "R7 restarted, A0 is data");
    check(prot_on, 1'b0, "R7 prot stays off");
    // R7: mismatching AA@1555 becomes new first step; R2 arm
    wr(13'h1555, 8'hAA, 1'b0, "R3 step1");
    wr(13'h1555, 8'hAA, 1'b0, "R7 restart as step1");
    wr(13'h0AAA, 8'h55, 1'b0, "R3 step2");
    wr(13'h1555, 8'hA0, 1'b0, "R3 step3");
    check(prot_on, 1'b1, "R2 armed after third write");
    // R4: locked
    expire();
    wr(13'h0100, 8'h11, 1'b0, "R4 locked write blocked");
    // R5: prefix unlocks until window expiry
    wr(13'h1555, 8'hAA, 1'b0, "R3 prefix1");
    wr(13'h0AAA, 8'h55, 1'b0, "R3 prefix2");
    wr(13'h1555, 8'hA0, 1'b0, "R3 prefix3");
    wr(13'h0200, 8'h22, 1'b1, "R5 unlocked write 0");
    wr(13'h0201, 8'h23, 1'b1, "R5 unlocked write 1");
    expire();
    wr(13'h0202, 8'h24, 1'b0, "R5 relocked after expiry");
    // R8: expiry abandons partial sequence
    wr(13'h1555, 8'hAA, 1'b0, "R8 step1");
    wr(13'h0AAA, 8'h55, 1'b0, "R8 step2");
    expire();
    wr(13'h1555, 8'hA0, 1'b0, "R8 A0 after expiry is locked data");
    wr(13'h0300, 8'h33, 1'b0, "R8 still locked");
    // R9: protection survives reset
    do_reset();
    wait_por();
    check(prot_on, 1'b1, "R9 prot survives reset");
    wr(13'h0301, 8'h34, 1'b0, "R9 R4 locked after reset");
    // R6: disable
    wr(13'h1555, 8'hAA, 1'b0, "R6 d1");
    wr(13'h0AAA, 8'h55, 1'b0, "R6 d2");
    wr(13'h1555, 8'h80, 1'b0, "R6 d3");
    wr(13'h1555, 8'hAA, 1'b0, "R6 d4");
    wr(13'h0AAA, 8'h55, 1'b0, "R6 d5");
    check(prot_on, 1'b1, "R6 still on before last step");
    wr(13'h1555, 8'h20, 1'b0, "R6 d6");
    check(prot_on, 1'b0, "R6 disarmed");
    wr(13'h0400, 8'h44, 1'b1, "R6 write allowed after disarm");
    do_reset();
    wait_por();
    check(prot_on, 1'b0, "R9 off state survives reset");
    wr(13'h0401, 8'h45, 1'b1, "R1 write after reset");
    repeat (3) @(negedge clk);
    check(q.size() == 0, 1'b1, "R1 scoreboard drained");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule